// File: doc/BRIEF.md
# Stacked rotating register renamer

This block turns a logical integer register number into a physical slot of a 128-entry register file, and a logical predicate number into a physical slot of a 64-entry predicate file. The bottom 32 integer registers are shared by every procedure and map to themselves. The remaining 96 slots act as a circular window. Each procedure sees its own frame there, starting at logical 32. A procedure call advances the window past the caller's local registers, so the caller's output registers become the callee's first registers. A return restores the caller's view from a small internal stack of saved frame descriptors.

Inside a frame, a leading region whose size is a multiple of 8 can rotate. Each loop-rotate event moves every value one logical position up, wrapping within the region. This is done by stepping a rotation base, so no data moves. The predicate file has a fixed rotating region covering entries 16 to 63 and a rotation base of its own. A logical integer index that falls beyond the current frame raises a violation flag.

The translation is combinational from the registered frame state. Control events are applied at the clock edge. Error pulses appear in the cycle after the offending event.

Top module: `rrn_renamer`

## Requirements
- R1: An integer index below 32 gives `gr_phys_o` equal to the index, with `gr_viol_o` low.
- R2: For an integer index i of 32 or more, let k = i - 32. If k is not less than the frame size, `gr_viol_o` is high and `gr_phys_o` is 0. Otherwise, if k is not inside the rotating region, `gr_phys_o` = 32 + ((base + k) mod 96).
- R3: If k is less than the rotating size, `gr_phys_o` = 32 + ((base + ((k + rrb) mod rotating size)) mod 96), where rrb is the integer rotation base.
- R4: An accepted allocate (`op_i` = 1) does four things. It sets the frame size to `alloc_local_i` + `alloc_out_i`, the local size to `alloc_local_i` and the rotating size to `alloc_rot_i`. It zeroes the integer rotation base. It leaves the frame base and the predicate rotation base unchanged.
- R5: An allocate is rejected when any of these holds: local + output exceeds 96, the rotating size is not a multiple of 8, or the rotating size exceeds local + output. A rejected allocate leaves all state unchanged, and `alloc_err_o` is high for exactly the following cycle.
- R6: A call (`op_i` = 2) pushes the current frame. The new base is (base + local size) mod 96. The new frame size is the old frame size minus the old local size. The local size, the rotating size and both rotation bases become zero.
- R7: A return (`op_i` = 3) restores the base, the sizes and both rotation bases saved by the matching call.
- R8: A call when the marker stack already holds MARKER_DEPTH (default 4) frames, or a return when it is empty, changes no state, and `stack_err_o` is high for exactly the following cycle.
- R9: A rotate (`op_i` = 4) sets the integer base to (rrb - 1) mod rotating size, or leaves it at 0 when the rotating size is 0. It sets the predicate base to (prrb - 1) mod 48. After the event, each logical register in a region maps where the next lower one (with wrap) mapped before.
- R10: A clear (`op_i` = 5) sets both rotation bases to zero and nothing else. Codes 0, 6 and 7 do nothing.
- R11: A predicate index below 16 maps to itself. Any other predicate index p maps to 16 + ((p - 16 + prrb) mod 48).
- R12: After reset, the base, all sizes, both rotation bases and the marker stack are zero or empty, and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Event code: 0 idle, 1 allocate, 2 call, 3 return, 4 rotate, 5 clear rotation |
| alloc_local_i | input | 7 | Local area size for allocate |
| alloc_out_i | input | 7 | Output area size for allocate |
| alloc_rot_i | input | 7 | Rotating region size for allocate |
| gr_idx_i | input | 7 | Logical integer register index |
| gr_phys_o | output | 7 | Physical integer register index |
| gr_viol_o | output | 1 | Index lies outside the current frame |
| pr_idx_i | input | 6 | Logical predicate index |
| pr_phys_o | output | 6 | Physical predicate index |
| alloc_err_o | output | 1 | Rejected allocate, one-cycle pulse |
| stack_err_o | output | 1 | Marker stack overflow or underflow, one-cycle pulse |

## Verification
The two functions that meet in one cycle are a state-changing event at the clock edge and the translation looked up in the same cycle. The lookup in the event's cycle must still use the old frame, and the lookup in the next cycle must use the new one. The bench drives an event together with a lookup index every cycle. It compares that cycle's translation against the reference model's pre-event state, and it compares the error pulses against the model in the following cycle. A rotation base that wraps while the frame base also wraps past 96 is provoked by a deep frame placed at base 90. The full index range is then swept and judged against the model's arithmetic.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  localparam int unsigned GR_W = 7;
  localparam int unsigned PR_W = 6;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ALLOC = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_ROT   = 3'd4,
    OP_CLR   = 3'd5
  } rrn_op_e;

  typedef struct packed {
    logic [GR_W-1:0] base;
    logic [GR_W-1:0] size;
    logic [GR_W-1:0] loc;
    logic [GR_W-1:0] rot;
    logic [GR_W-1:0] rrb;
    logic [PR_W-1:0] prrb;
  } frame_t;
endpackage

// File: rtl/rrn_frame_ctrl.sv
module rrn_frame_ctrl
  import rrn_pkg::*;
#(
  parameter int unsigned STACKED = 96,
  parameter int unsigned PR_ROT  = 48,
  parameter int unsigned DEPTH   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  rrn_op_e         op_i,
  input  logic [GR_W-1:0] loc_i,
  input  logic [GR_W-1:0] out_i,
  input  logic [GR_W-1:0] rot_i,
  output frame_t          cur_o,
  output logic            alloc_err_o,
  output logic            stack_err_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t          cur_q, cur_d;
  frame_t          mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m1;
  logic [GR_W:0]   fsum, bsum;
  logic            bad_alloc, full, empty, push, aerr_d, serr_d;

  assign fsum   = {1'b0, loc_i} + {1'b0, out_i};
  assign bsum   = {1'b0, cur_q.base} + {1'b0, cur_q.loc};
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign cnt_m1 = cnt_q - 1'b1;
  assign bad_alloc = (fsum > (GR_W+1)'(STACKED)) || (rot_i[2:0] != 3'd0) ||
                     ({1'b0, rot_i} > fsum);
  assign push   = (op_i == OP_CALL) && !full;

  always_comb begin
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    aerr_d = 1'b0;
    serr_d = 1'b0;
    case (op_i)
      OP_ALLOC: begin
        if (bad_alloc) aerr_d = 1'b1;
        else begin
          cur_d.size = fsum[GR_W-1:0];
          cur_d.loc  = loc_i;
          cur_d.rot  = rot_i;
          cur_d.rrb  = '0;
        end
      end
      OP_CALL: begin
        if (full) serr_d = 1'b1;
        else begin
          cnt_d      = cnt_q + 1'b1;
          cur_d.base = (bsum >= (GR_W+1)'(STACKED)) ? GR_W'(bsum - (GR_W+1)'(STACKED))
                                                     : bsum[GR_W-1:0];
          cur_d.size = cur_q.size - cur_q.loc;
          cur_d.loc  = '0;
          cur_d.rot  = '0;
          cur_d.rrb  = '0;
          cur_d.prrb = '0;
        end
      end
      OP_RET: begin
        if (empty) serr_d = 1'b1;
        else begin
          cnt_d = cnt_m1;
          cur_d = mem_q[cnt_m1[PTR_W-1:0]];
        end
      end
      OP_ROT: begin
        if (cur_q.rot != '0)
          cur_d.rrb = (cur_q.rrb == '0) ? cur_q.rot - 1'b1 : cur_q.rrb - 1'b1;
        cur_d.prrb = (cur_q.prrb == '0) ? PR_W'(PR_ROT - 1) : cur_q.prrb - 1'b1;
      end
      OP_CLR: begin
        cur_d.rrb  = '0;
        cur_d.prrb = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      cnt_q       <= '0;
      alloc_err_o <= 1'b0;
      stack_err_o <= 1'b0;
    end else begin
      cur_q       <= cur_d;
      cnt_q       <= cnt_d;
      alloc_err_o <= aerr_d;
      stack_err_o <= serr_d;
    end
  end

  // marker storage needs no reset: reads are guarded by the count
  always_ff @(posedge clk_i) begin
    if (push) mem_q[cnt_q[PTR_W-1:0]] <= cur_q;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/rrn_gr_map.sv
module rrn_gr_map
  import rrn_pkg::*;
#(
  parameter int unsigned STATIC  = 32,
  parameter int unsigned STACKED = 96
) (
  input  logic [GR_W-1:0] idx_i,
  input  frame_t          frame_i,
  output logic [GR_W-1:0] phys_o,
  output logic            viol_o
);
  logic [GR_W-1:0] off, loff;
  logic [GR_W:0]   rsum, rwrap, psum, pwrap;
  logic            stacked, in_rot;

  assign stacked = (idx_i >= GR_W'(STATIC));
  assign off     = idx_i - GR_W'(STATIC);
  assign in_rot  = (off < frame_i.rot);
  assign rsum    = {1'b0, off} + {1'b0, frame_i.rrb};
  assign rwrap   = (rsum >= {1'b0, frame_i.rot}) ? rsum - {1'b0, frame_i.rot} : rsum;
  assign loff    = in_rot ? rwrap[GR_W-1:0] : off;
  assign psum    = {1'b0, frame_i.base} + {1'b0, loff};
  assign pwrap   = (psum >= (GR_W+1)'(STACKED)) ? psum - (GR_W+1)'(STACKED) : psum;

  always_comb begin
    viol_o = 1'b0;
    phys_o = idx_i;
    if (stacked) begin
      if (off >= frame_i.size) begin
        viol_o = 1'b1;
        phys_o = '0;
      end else begin
        phys_o = GR_W'(STATIC) + pwrap[GR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rrn_pr_map.sv
module rrn_pr_map
  import rrn_pkg::*;
#(
  parameter int unsigned STATIC = 16,
  parameter int unsigned ROT    = 48
) (
  input  logic [PR_W-1:0] idx_i,
  input  logic [PR_W-1:0] prrb_i,
  output logic [PR_W-1:0] phys_o
);
  logic [PR_W:0] sum, wrap;

  assign sum  = {1'b0, idx_i - PR_W'(STATIC)} + {1'b0, prrb_i};
  assign wrap = (sum >= (PR_W+1)'(ROT)) ? sum - (PR_W+1)'(ROT) : sum;
  assign phys_o = (idx_i < PR_W'(STATIC)) ? idx_i : PR_W'(STATIC) + wrap[PR_W-1:0];
endmodule

// File: rtl/rrn_renamer.sv
module rrn_renamer
  import rrn_pkg::*;
#(
  parameter int unsigned GR_STATIC    = 32,
  parameter int unsigned PR_STATIC    = 16,
  parameter int unsigned MARKER_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      op_i,
  input  logic [GR_W-1:0] alloc_local_i,
  input  logic [GR_W-1:0] alloc_out_i,
  input  logic [GR_W-1:0] alloc_rot_i,
  input  logic [GR_W-1:0] gr_idx_i,
  output logic [GR_W-1:0] gr_phys_o,
  output logic            gr_viol_o,
  input  logic [PR_W-1:0] pr_idx_i,
  output logic [PR_W-1:0] pr_phys_o,
  output logic            alloc_err_o,
  output logic            stack_err_o
);
  localparam int unsigned GR_STACKED = (1 << GR_W) - GR_STATIC;
  localparam int unsigned PR_ROT     = (1 << PR_W) - PR_STATIC;

  frame_t frame;

  rrn_frame_ctrl #(
    .STACKED(GR_STACKED),
    .PR_ROT (PR_ROT),
    .DEPTH  (MARKER_DEPTH)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (rrn_op_e'(op_i)),
    .loc_i      (alloc_local_i),
    .out_i      (alloc_out_i),
    .rot_i      (alloc_rot_i),
    .cur_o      (frame),
    .alloc_err_o(alloc_err_o),
    .stack_err_o(stack_err_o)
  );

  rrn_gr_map #(
    .STATIC (GR_STATIC),
    .STACKED(GR_STACKED)
  ) u_gr (
    .idx_i  (gr_idx_i),
    .frame_i(frame),
    .phys_o (gr_phys_o),
    .viol_o (gr_viol_o)
  );

  rrn_pr_map #(
    .STATIC(PR_STATIC),
    .ROT   (PR_ROT)
  ) u_pr (
    .idx_i (pr_idx_i),
    .prrb_i(frame.prrb),
    .phys_o(pr_phys_o)
  );
endmodule

// File: rtl/rrn_renamer_chk.sv
module rrn_renamer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] op_i,
  input logic [6:0] alloc_rot_i,
  input logic [6:0] gr_idx_i,
  input logic [6:0] gr_phys_o,
  input logic       gr_viol_o,
  input logic [5:0] pr_idx_i,
  input logic [5:0] pr_phys_o,
  input logic       alloc_err_o,
  input logic       stack_err_o
);
  assert_static_gr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gr_idx_i < 7'd32) |-> (gr_phys_o == gr_idx_i && !gr_viol_o));

  assert_viol_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gr_viol_o |-> (gr_phys_o == 7'd0 && gr_idx_i >= 7'd32));

  assert_stacked_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gr_idx_i >= 7'd32 && !gr_viol_o) |-> (gr_phys_o >= 7'd32));

  assert_bad_rot_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && alloc_rot_i[2:0] != 3'd0) |=> alloc_err_o);

  assert_alloc_err_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_err_o |-> ($past(op_i) == 3'd1));

  assert_stack_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_err_o |-> ($past(op_i) == 3'd2 || $past(op_i) == 3'd3));

  assert_static_pr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_idx_i < 6'd16) |-> (pr_phys_o == pr_idx_i));

  assert_rot_pr_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_idx_i >= 6'd16) |-> (pr_phys_o >= 6'd16));
endmodule

bind rrn_renamer rrn_renamer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .alloc_rot_i(alloc_rot_i),
  .gr_idx_i   (gr_idx_i),
  .gr_phys_o  (gr_phys_o),
  .gr_viol_o  (gr_viol_o),
  .pr_idx_i   (pr_idx_i),
  .pr_phys_o  (pr_phys_o),
  .alloc_err_o(alloc_err_o),
  .stack_err_o(stack_err_o)
);

// File: tb/tb_rrn_renamer.sv
`timescale 1ns/1ps
module tb_rrn_renamer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] op_i = '0;
  logic [6:0] alloc_local_i = '0, alloc_out_i = '0, alloc_rot_i = '0, gr_idx_i = '0;
  logic [5:0] pr_idx_i = '0;
  logic [6:0] gr_phys_o;
  logic [5:0] pr_phys_o;
  logic       gr_viol_o, alloc_err_o, stack_err_o;

  int checks = 0, errors = 0;
  string phase = "R12";

  // reference model state
  int m_base = 0, m_size = 0, m_loc = 0, m_rot = 0, m_rrb = 0, m_prrb = 0;
  int saved[$];
  bit e_aerr = 0, e_serr = 0;

  always #5 clk_i = ~clk_i;

  rrn_renamer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i),
    .alloc_local_i(alloc_local_i), .alloc_out_i(alloc_out_i), .alloc_rot_i(alloc_rot_i),
    .gr_idx_i(gr_idx_i), .gr_phys_o(gr_phys_o), .gr_viol_o(gr_viol_o),
    .pr_idx_i(pr_idx_i), .pr_phys_o(pr_phys_o),
    .alloc_err_o(alloc_err_o), .stack_err_o(stack_err_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    summary();
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  task automatic check_now();
    int k, lo, p; bit v; string tag;
    int g = int'(gr_idx_i), q = int'(pr_idx_i);
    if (g < 32) begin p = g; v = 0; tag = "R1"; end
    else begin
      k = g - 32;
      if (k >= m_size) begin p = 0; v = 1; tag = "R2"; end
      else begin
        if (k < m_rot) begin lo = (k + m_rrb) % m_rot; tag = "R3"; end
        else begin lo = k; tag = "R2"; end
        p = 32 + (m_base + lo) % 96; v = 0;
      end
    end
    check(tag, int'(gr_phys_o), p, $sformatf("gr_phys idx %0d", g));
    check(tag, int'(gr_viol_o), int'(v), $sformatf("gr_viol idx %0d", g));
    check("R11", int'(pr_phys_o), (q < 16) ? q : 16 + (q - 16 + m_prrb) % 48,
          $sformatf("pr_phys idx %0d", q));
    check("R5", int'(alloc_err_o), int'(e_aerr), "alloc_err");
    check("R8", int'(stack_err_o), int'(e_serr), "stack_err");
  endtask

  task automatic model_apply(int op, int l, int o, int r);
    e_aerr = 0; e_serr = 0;
    case (op)
      1: if (l + o > 96 || r % 8 != 0 || r > l + o) e_aerr = 1;
         else begin m_size = l + o; m_loc = l; m_rot = r; m_rrb = 0; end
      2: if (saved.size() == 4 * 6) e_serr = 1;
         else begin
           saved.push_back(m_base); saved.push_back(m_size); saved.push_back(m_loc);
           saved.push_back(m_rot);  saved.push_back(m_rrb);  saved.push_back(m_prrb);
           m_base = (m_base + m_loc) % 96; m_size = m_size - m_loc;
           m_loc = 0; m_rot = 0; m_rrb = 0; m_prrb = 0;
         end
      3: if (saved.size() == 0) e_serr = 1;
         else begin
           m_prrb = saved.pop_back(); m_rrb = saved.pop_back(); m_rot = saved.pop_back();
           m_loc = saved.pop_back();  m_size = saved.pop_back(); m_base = saved.pop_back();
         end
      4: begin
           if (m_rot != 0) m_rrb = (m_rrb + m_rot - 1) % m_rot;
           m_prrb = (m_prrb + 47) % 48;
         end
      5: begin m_rrb = 0; m_prrb = 0; end
      default: ;
    endcase
  endtask

  // event applied at the coming edge; lookup compared against pre-event state
  task automatic cyc(int op, int l, int o, int r, int gi, int pi);
    @(negedge clk_i);
    op_i = 3'(op); alloc_local_i = 7'(l); alloc_out_i = 7'(o); alloc_rot_i = 7'(r);
    gr_idx_i = 7'(gi); pr_idx_i = 6'(pi);
    #1;
    check_now();
    @(posedge clk_i);
    model_apply(op, l, o, r);
  endtask

  task automatic sweep();
    for (int i = 0; i < 128; i++) cyc(0, 0, 0, 0, i, i % 64);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    phase = "R12"; sweep();

    phase = "R4";  cyc(1, 10, 6, 8, 33, 16); sweep();
    phase = "R9";  for (int i = 0; i < 3; i++) cyc(4, 0, 0, 0, 32 + i, 17); sweep();
    phase = "R5";  cyc(1, 8, 8, 12, 40, 20); cyc(1, 8, 8, 24, 41, 21);
                   cyc(1, 90, 7, 0, 42, 22); sweep();
    phase = "R6";  cyc(2, 0, 0, 0, 35, 30); sweep();
    phase = "R4";  cyc(1, 20, 8, 16, 50, 40);
    phase = "R9";  for (int i = 0; i < 5; i++) cyc(4, 0, 0, 0, 40 + i, 63); sweep();
    phase = "R10"; cyc(5, 0, 0, 0, 45, 50); sweep();
    phase = "R6";  cyc(2, 0, 0, 0, 60, 5); cyc(2, 0, 0, 0, 61, 6); cyc(2, 0, 0, 0, 62, 7);
    phase = "R8";  cyc(2, 0, 0, 0, 33, 8); sweep();
    phase = "R7";  cyc(3, 0, 0, 0, 34, 9); cyc(3, 0, 0, 0, 35, 10); sweep();
                   cyc(3, 0, 0, 0, 36, 11); cyc(3, 0, 0, 0, 37, 12); sweep();
    phase = "R8";  cyc(3, 0, 0, 0, 38, 13); sweep();
    phase = "R3";  cyc(1, 90, 6, 0, 32, 16); cyc(2, 0, 0, 0, 32, 16);
                   cyc(1, 6, 40, 40, 32, 16);
                   for (int i = 0; i < 2; i++) cyc(4, 0, 0, 0, 70, 60); sweep();
    phase = "R6";  cyc(2, 0, 0, 0, 32, 16); sweep();
    phase = "R7";  cyc(3, 0, 0, 0, 32, 16); cyc(3, 0, 0, 0, 33, 17); sweep();
    cyc(0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule